// File: doc/BRIEF.md
# Stream-Cipher Block Key Word Generator

This block supplies the pair of 32-bit key words that a stream-cipher round needs for one block. The caller keeps eight 32-bit working key words (already mixed), four 32-bit nonce words, the raw key length in bytes and the current block index. On each request the block stretches the four nonce words to eight and returns the two words for that block.

The first word is a working key word chosen by the block index modulo 8. The second word is the sum modulo 2^32 of five terms: the working key word four positions further on, an expanded nonce word, a tweak chosen by the index modulo 4, the index itself, and the constant 8. Results are latched, and a valid strobe follows each request by one cycle. A parameter can also make the outputs purely combinational.

Top module: `kwg_keyword_gen`

## Requirements
- R1: While reset is high, and in the cycle after it is released, `kw_valid_o` is 0, and `kw0_o` and `kw1_o` are 0.
- R2: `kw_valid_o` is 1 in the cycle after a cycle in which `req_i` is 1. It is 0 in the cycle after a cycle in which `req_i` is 0.
- R3: `kw0_o` equals working key word K[i mod 8]. Word Kk sits at bits [32k+31:32k] of `key_words_i`.
- R4: `kw1_o` equals K[(i+4) mod 8] + M[i mod 8] + T + i + 8, modulo 2^32. M is the expanded nonce and T is the tweak.
- R5: The expanded nonce takes M[k] = Nk for k = 0..3. For k = 4..7 it takes M[k] = (k−4) − N(k−4) modulo 2^32. Nonce word Nk sits at bits [32k+31:32k] of `nonce_i`.
- R6: When i mod 4 = 1, T is 4 times `key_len_i`.
- R7: When i mod 4 = 3, T is floor((i+8)/2^31). Here i+8 is taken without wrap, so T is 0, 1 or 2 and it reaches 2 near the top of the index range.
- R8: When i mod 4 is 0 or 2, T is 0, so `key_len_i` has no effect on `kw1_o`.
- R9: While `req_i` is 0, `kw0_o` and `kw1_o` keep their values whatever the other inputs do.
- R10: The i + 8 term wraps modulo 2^32 inside the sum for indices near 2^32 − 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Request the key words for `blk_idx_i` |
| blk_idx_i | input | 32 | Block index i |
| key_len_i | input | 6 | Raw key length in bytes (0..32) |
| key_words_i | input | 256 | Eight working key words, K0 in the low bits |
| nonce_i | input | 128 | Four nonce words, N0 in the low bits |
| kw0_o | output | 32 | First key word of the block |
| kw1_o | output | 32 | Second key word of the block |
| kw_valid_o | output | 1 | The outputs belong to the previous request |

## Verification
The bench covers every residue of the index modulo 4 and modulo 8. It uses an all-zero key and nonce, where the nonce offsets k−4 show up directly: an expansion that drops the offset or adds instead of subtracting gives a wrong `kw1_o`. Two indices probe the floor tweak. Index 0x7FFFFFFB must add 1 and index 0xFFFFFFFB must add 2. A design that keeps only one carry bit, or that computes i+8 in 32 bits, loses the 2 there, and an unwrapped sum would spill into a wrong word. The bench also changes the key length on indices that do not use it, and changes the inputs between requests, to catch a tweak that leaks into other residues and outputs that are not held.

// File: rtl/kwg_pkg.sv
package kwg_pkg;

    localparam int WORD_W    = 32;
    localparam int KEY_WORDS = 8;
    localparam int NONCE_IN  = 4;
    localparam int LEN_W     = 6;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [1:0] {
        PHASE_PLAIN0 = 2'd0,
        PHASE_KEYLEN = 2'd1,
        PHASE_PLAIN2 = 2'd2,
        PHASE_CARRY  = 2'd3
    } tweak_phase_e;

    typedef struct packed {
        word_t kw0;
        word_t kw1;
    } kw_pair_t;

    // Expanded nonce word for upper positions: offset minus user word.
    function automatic word_t nonce_upper(input int unsigned ofs, input word_t n);
        return word_t'(ofs) - n;
    endfunction

endpackage

// File: rtl/kwg_nonce_expand.sv
module kwg_nonce_expand #(
    parameter int W   = kwg_pkg::WORD_W,
    parameter int NIN = kwg_pkg::NONCE_IN
) (
    input  logic [NIN*W-1:0]   nonce_i,
    output logic [2*NIN*W-1:0] nonce_x_o
);
    import kwg_pkg::*;

    for (genvar k = 0; k < NIN; k++) begin : g_words
        assign nonce_x_o[k*W +: W]       = nonce_i[k*W +: W];
        assign nonce_x_o[(NIN+k)*W +: W] = nonce_upper(k, nonce_i[k*W +: W]);
    end
endmodule

// File: rtl/kwg_word_pick.sv
module kwg_word_pick #(
    parameter int W  = kwg_pkg::WORD_W,
    parameter int NW = kwg_pkg::KEY_WORDS,
    localparam int SEL_W = $clog2(NW)
) (
    input  logic [NW*W-1:0] words_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic [W-1:0]     word_o
);
    always_comb begin
        word_o = '0;
        for (int k = 0; k < NW; k++) begin
            if (sel_i == SEL_W'(k)) word_o = words_i[k*W +: W];
        end
    end
endmodule

// File: rtl/kwg_tweak_sel.sv
module kwg_tweak_sel #(
    parameter int W     = kwg_pkg::WORD_W,
    parameter int LEN_W = kwg_pkg::LEN_W,
    parameter int BIAS  = kwg_pkg::KEY_WORDS
) (
    input  logic [W-1:0]     idx_i,
    input  logic [LEN_W-1:0] key_len_i,
    output logic [W-1:0]     ctr_o,
    output logic [W-1:0]     tweak_o
);
    import kwg_pkg::*;

    logic [W:0]   ctr_wide;
    tweak_phase_e phase;

    assign ctr_wide = {1'b0, idx_i} + (W+1)'(BIAS);
    assign ctr_o    = ctr_wide[W-1:0];
    assign phase    = tweak_phase_e'(idx_i[1:0]);

    always_comb begin
        unique case (phase)
            PHASE_KEYLEN: tweak_o = {{(W-LEN_W-2){1'b0}}, key_len_i, 2'b00};
            PHASE_CARRY:  tweak_o = {{(W-2){1'b0}}, ctr_wide[W:W-1]};
            default:      tweak_o = '0;
        endcase
    end
endmodule

// File: rtl/kwg_keyword_gen.sv
module kwg_keyword_gen #(
    parameter int W       = kwg_pkg::WORD_W,
    parameter int NW      = kwg_pkg::KEY_WORDS,
    parameter int NIN     = kwg_pkg::NONCE_IN,
    parameter int LEN_W   = kwg_pkg::LEN_W,
    parameter bit REG_OUT = 1'b1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_i,
    input  logic [W-1:0]       blk_idx_i,
    input  logic [LEN_W-1:0]   key_len_i,
    input  logic [NW*W-1:0]    key_words_i,
    input  logic [NIN*W-1:0]   nonce_i,
    output logic [W-1:0]       kw0_o,
    output logic [W-1:0]       kw1_o,
    output logic               kw_valid_o
);
    import kwg_pkg::*;

    localparam int SEL_W = $clog2(NW);

    logic [2*NIN*W-1:0] nonce_x;
    logic [SEL_W-1:0]   sel_lo, sel_hi;
    logic [W-1:0]       k_lo, k_hi, n_sel, ctr, tweak;
    kw_pair_t           pair_c;

    assign sel_lo = blk_idx_i[SEL_W-1:0];
    assign sel_hi = sel_lo + SEL_W'(NW/2);

    kwg_nonce_expand #(.W(W), .NIN(NIN)) u_nonce (
        .nonce_i   (nonce_i),
        .nonce_x_o (nonce_x)
    );

    kwg_word_pick #(.W(W), .NW(NW)) u_pick_lo (
        .words_i (key_words_i), .sel_i (sel_lo), .word_o (k_lo)
    );

    kwg_word_pick #(.W(W), .NW(NW)) u_pick_hi (
        .words_i (key_words_i), .sel_i (sel_hi), .word_o (k_hi)
    );

    kwg_word_pick #(.W(W), .NW(2*NIN)) u_pick_n (
        .words_i (nonce_x), .sel_i (sel_lo), .word_o (n_sel)
    );

    kwg_tweak_sel #(.W(W), .LEN_W(LEN_W), .BIAS(NW)) u_tweak (
        .idx_i     (blk_idx_i),
        .key_len_i (key_len_i),
        .ctr_o     (ctr),
        .tweak_o   (tweak)
    );

    assign pair_c.kw0 = k_lo;
    assign pair_c.kw1 = k_hi + n_sel + tweak + ctr;

    if (REG_OUT) begin : g_reg
        kw_pair_t pair_q;
        logic     valid_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                pair_q  <= '0;
                valid_q <= 1'b0;
            end else begin
                valid_q <= req_i;
                if (req_i) pair_q <= pair_c;
            end
        end
        assign kw0_o      = pair_q.kw0;
        assign kw1_o      = pair_q.kw1;
        assign kw_valid_o = valid_q;
    end else begin : g_comb
        assign kw0_o      = pair_c.kw0;
        assign kw1_o      = pair_c.kw1;
        assign kw_valid_o = req_i;
    end
endmodule

// File: rtl/kwg_keyword_gen_chk.sv
module kwg_keyword_gen_chk #(
    parameter int W       = kwg_pkg::WORD_W,
    parameter int NW      = kwg_pkg::KEY_WORDS,
    parameter bit REG_OUT = 1'b1
) (
    input logic            clk,
    input logic            rst,
    input logic            req_i,
    input logic [W-1:0]    blk_idx_i,
    input logic [NW*W-1:0] key_words_i,
    input logic [W-1:0]    kw0_o,
    input logic [W-1:0]    kw1_o,
    input logic            kw_valid_o
);
    localparam int SEL_W = $clog2(NW);

    logic [W-1:0] want_kw0;
    assign want_kw0 = key_words_i[32'(blk_idx_i[SEL_W-1:0]) * W +: W];

    if (REG_OUT) begin : g_chk
        // R2: strobe follows a request
        a_r2_valid_after_req: assert property (@(posedge clk) disable iff (rst)
            req_i |=> kw_valid_o);
        // R2: no strobe without a request
        a_r2_no_spurious_valid: assert property (@(posedge clk) disable iff (rst)
            !req_i |=> !kw_valid_o);
        // R9: results held between requests
        a_r9_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
            !req_i |=> ($stable(kw0_o) && $stable(kw1_o)));
        // R3: first word is the selected key word
        a_r3_kw0_select: assert property (@(posedge clk) disable iff (rst)
            req_i |=> (kw0_o == $past(want_kw0)));
    end
endmodule

bind kwg_keyword_gen kwg_keyword_gen_chk #(.W(W), .NW(NW), .REG_OUT(REG_OUT)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .req_i       (req_i),
    .blk_idx_i   (blk_idx_i),
    .key_words_i (key_words_i),
    .kw0_o       (kw0_o),
    .kw1_o       (kw1_o),
    .kw_valid_o  (kw_valid_o)
);

// File: tb/tb_kwg_keyword_gen.sv
module tb_kwg_keyword_gen;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         req_i = 1'b0;
    logic [31:0]  blk_idx_i = '0;
    logic [5:0]   key_len_i = 6'd32;
    logic [255:0] key_words_i = '0;
    logic [127:0] nonce_i = '0;
    logic [31:0]  kw0_o, kw1_o;
    logic         kw_valid_o;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    kwg_keyword_gen dut (
        .clk(clk), .rst(rst), .req_i(req_i), .blk_idx_i(blk_idx_i),
        .key_len_i(key_len_i), .key_words_i(key_words_i), .nonce_i(nonce_i),
        .kw0_o(kw0_o), .kw1_o(kw1_o), .kw_valid_o(kw_valid_o)
    );

    localparam int NVEC = 12;
    localparam logic [31:0] VEC_IDX [NVEC] = '{
        32'd0, 32'd1, 32'd2, 32'd3, 32'd4, 32'd5, 32'd6, 32'd7,
        32'd13, 32'h7FFF_FFFB, 32'hFFFF_FFFB, 32'hFFFF_FFFD
    };
    localparam logic [5:0] VEC_LEN [NVEC] = '{
        6'd32, 6'd32, 6'd7, 6'd32, 6'd32, 6'd16, 6'd32, 6'd32,
        6'd5, 6'd32, 6'd32, 6'd32
    };

    function automatic logic [31:0] kword(input logic [255:0] kv, input int n);
        return kv[n*32 +: 32];
    endfunction

    // Model built from R4..R8, R10
    function automatic logic [31:0] model_kw1(input logic [31:0] i, input logic [5:0] len,
                                              input logic [255:0] kv, input logic [127:0] nv);
        logic [31:0] m [8];
        logic [63:0] wide;
        logic [31:0] t;
        for (int k = 0; k < 4; k++) begin
            m[k]   = nv[k*32 +: 32];
            m[k+4] = 32'(k) - nv[k*32 +: 32];
        end
        wide = 64'(i) + 64'd8;
        case (i % 4)
            1: t = 32'(len) * 32'd4;
            3: t = 32'(wide >> 31);
            default: t = 32'd0;
        endcase
        return kword(kv, int'((i + 32'd4) % 8)) + m[i % 8] + t + i + 32'd8;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic request(input logic [31:0] i, input logic [5:0] len);
        @(negedge clk);
        req_i = 1'b1; blk_idx_i = i; key_len_i = len;
        @(negedge clk);
        req_i = 1'b0;
    endtask

    initial begin
        #(5.0 * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] h0, h1;
        repeat (3) @(negedge clk);
        check("R1 valid in reset", 32'(kw_valid_o), 32'd0);
        check("R1 kw0 in reset", kw0_o, 32'd0);
        check("R1 kw1 in reset", kw1_o, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 valid after reset", 32'(kw_valid_o), 32'd0);
        check("R1 kw1 after reset", kw1_o, 32'd0);

        // Directed, zero key and nonce: R5 offsets, R6, R7, R10
        request(32'd0, 6'd32);
        check("R4 zero i=0", kw1_o, 32'd8);
        request(32'd5, 6'd32);
        check("R5/R6 zero i=5", kw1_o, 32'd142);
        request(32'd7, 6'd32);
        check("R5/R7 zero i=7", kw1_o, 32'd18);
        request(32'h7FFF_FFFB, 6'd32);
        check("R7 floor one", kw1_o, 32'h8000_0004);
        request(32'hFFFF_FFFB, 6'd32);
        check("R7/R10 floor two", kw1_o, 32'd5);

        // Table walk with a populated key and nonce
        for (int k = 0; k < 8; k++) key_words_i[k*32 +: 32] = 32'h9E37_79B9 * 32'(k + 3);
        for (int k = 0; k < 4; k++) nonce_i[k*32 +: 32] = 32'hC2B2_AE35 ^ (32'h0101_0101 << k);
        for (int v = 0; v < NVEC; v++) begin
            request(VEC_IDX[v], VEC_LEN[v]);
            check("R2 valid", 32'(kw_valid_o), 32'd1);
            check("R3 kw0", kw0_o, kword(key_words_i, int'(VEC_IDX[v] % 8)));
            check("R4 kw1", kw1_o, model_kw1(VEC_IDX[v], VEC_LEN[v], key_words_i, nonce_i));
        end

        // R8: key length must not matter for i mod 4 in {0,2}
        request(32'd6, 6'd0);
        h1 = kw1_o;
        request(32'd6, 6'd31);
        check("R8 len ignored i=6", kw1_o, h1);
        request(32'd8, 6'd0);
        h1 = kw1_o;
        request(32'd8, 6'd29);
        check("R8 len ignored i=8", kw1_o, h1);

        // R9 and R2: idle cycles hold outputs, no strobe
        h0 = kw0_o; h1 = kw1_o;
        @(negedge clk);
        blk_idx_i = 32'd3; key_len_i = 6'd1; key_words_i = ~key_words_i; nonce_i = ~nonce_i;
        @(negedge clk);
        check("R2 no valid idle", 32'(kw_valid_o), 32'd0);
        check("R9 kw0 held", kw0_o, h0);
        check("R9 kw1 held", kw1_o, h1);

        // Back-to-back requests
        @(negedge clk);
        req_i = 1'b1; blk_idx_i = 32'd9; key_len_i = 6'd32;
        @(negedge clk);
        check("R4 b2b first", kw1_o, model_kw1(32'd9, 6'd32, key_words_i, nonce_i));
        blk_idx_i = 32'd11;
        @(negedge clk);
        req_i = 1'b0;
        check("R2 b2b valid", 32'(kw_valid_o), 32'd1);
        check("R7 b2b second", kw1_o, model_kw1(32'd11, 6'd32, key_words_i, nonce_i));

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule